// File: doc/BRIEF.md
# Timer Interrupt Enable and Pending Register

This block collects the expiry events of five timer channels into one 32-bit control and status word. Each channel owns an enable bit and a sticky pending bit. A one-cycle expiry pulse from a channel sets that channel's pending bit. The block drives one level interrupt line per channel towards a vectored interrupt controller.

Software reads the whole word directly. A write does two things at once:
- It loads all enables from the low field.
- It clears every pending bit written as 1; a pending bit written as 0 is left as it is.

Writing the current enables with a zero pending field therefore updates the enables without losing events. Writing the enables with a single pending bit set acknowledges that one channel.

Top module: `tmr_irq_csr`

## Requirements
- R1: After a synchronous active-low reset, every bit of `rd_data` reads 0 and every `irq` line is 0.
- R2: On a clock edge with `wr_en` high, the enable of channel n (bit n of the word, n = 0..4, 1 = enabled) takes the value of `wr_data[n]`, visible on `rd_data` after that edge.
- R3: An `expire[n]` pulse sets the pending bit of channel n (word bit n+5) on that edge, whether or not the channel is enabled.
- R4: A write with `wr_data[n+5]` = 1 clears the pending bit of channel n. A pending bit written as 0 keeps its value, so a write with the pending field zeroed loses no event.
- R5: `irq[n]` is 1 exactly while channel n is both pending and enabled, and it stays asserted until one of the two drops.
- R6: If `expire[n]` and a write-one-to-clear of bit n+5 fall on the same edge, the pending bit ends at 1.
- R7: Word bits 10 to 31 always read 0, and writes to them have no effect.
- R8: With no expiry pulse and no clearing write, a pending bit keeps its value across edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| expire | input | 5 | One-cycle expiry pulse per timer channel |
| wr_en | input | 1 | Write strobe for the register word |
| wr_data | input | 32 | Write data: enables in bits 4:0, clear mask in bits 9:5 |
| rd_data | output | 32 | Current register word |
| irq | output | 5 | Level interrupt per channel (pending AND enabled) |

## Verification
Directed cases cover the following:
- An expiry on a disabled channel, which separates latching from enabling.
- An enable-only rewrite with the pending field zeroed, which shows that events are kept.
- A single-channel acknowledge, which shows that only that one bit is cleared.
- A collision of expiry and clear on one bit, which settles priority.
- A write of all ones, which probes the upper bits.

Random cycles then mix sparse and dense expiry pulses with random writes. This separates per-bit clear masking from whole-field clearing, and it separates level interrupts from pulsed ones.

// File: rtl/tmr_irq_pkg.sv
// Shared constants for the timer interrupt register.
// Assumes the word is 32 bits wide with the enable field at the bottom.
package tmr_irq_pkg;
    parameter int NUM_CH   = 5;
    parameter int WORD_W   = 32;
    parameter int PEND_LSB = NUM_CH;
    parameter int USED_W   = 2 * NUM_CH;
endpackage

// File: rtl/tmr_irq_chan.sv
// One channel: an enable flop and a sticky pending flop.
// A set from the expiry pulse wins over a clear on the same edge.
// Assumes expire is already synchronous to clk.
module tmr_irq_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic wr_en,
    input  logic en_wdata,
    input  logic clr_wdata,
    output logic en_q,
    output logic pend_q,
    output logic irq
);
    logic clr_req;

    // Clear request: a write with this channel's clear bit set.
    always_comb clr_req = wr_en & clr_wdata;

    // Enable flop, loaded on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (wr_en) en_q <= en_wdata;
    end

    // Pending flop: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (expire)  pend_q <= 1'b1;
        else if (clr_req) pend_q <= 1'b0;
    end

    // Level interrupt from the two held bits.
    always_comb irq = pend_q & en_q;

    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pend_q);
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && clr_req) |=> pend_q);
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !expire) |=> !pend_q);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!expire && !clr_req) |=> $stable(pend_q));
endmodule

// File: rtl/tmr_irq_pack.sv
// Packs the per-channel enable and pending bits into the register word.
// Bits above the used field are tied to zero.
module tmr_irq_pack #(
    parameter int NUM_CH = tmr_irq_pkg::NUM_CH,
    parameter int WORD_W = tmr_irq_pkg::WORD_W
) (
    input  logic [NUM_CH-1:0] en,
    input  logic [NUM_CH-1:0] pend,
    output logic [WORD_W-1:0] word
);
    localparam int USED_W = 2 * NUM_CH;

    // Assemble the readback word.
    always_comb begin
        word = '0;
        word[NUM_CH-1:0]      = en;
        word[USED_W-1:NUM_CH] = pend;
    end
endmodule

// File: rtl/tmr_irq_csr.sv
// Timer interrupt enable and pending register, top level.
// Enables live in bits NUM_CH-1:0 and pending bits in bits 2*NUM_CH-1:NUM_CH.
// Pending bits are write-one-to-clear.
// Assumes one register with no address decode and reads without side effects.
module tmr_irq_csr #(
    parameter int NUM_CH = tmr_irq_pkg::NUM_CH,
    parameter int WORD_W = tmr_irq_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] expire,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic [NUM_CH-1:0] irq
);
    localparam int USED_W = 2 * NUM_CH;

    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] pend_q;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        tmr_irq_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .expire    (expire[n]),
            .wr_en     (wr_en),
            .en_wdata  (wr_data[n]),
            .clr_wdata (wr_data[NUM_CH+n]),
            .en_q      (en_q[n]),
            .pend_q    (pend_q[n]),
            .irq       (irq[n])
        );

        p_irq_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
            irq[n] == (rd_data[n] && rd_data[NUM_CH+n]));
    end

    tmr_irq_pack #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_pack (
        .en   (en_q),
        .pend (pend_q),
        .word (rd_data)
    );

    p_en_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[NUM_CH-1:0] == $past(wr_data[NUM_CH-1:0]));
    p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[WORD_W-1:USED_W] == '0);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && irq == '0));
endmodule

// File: tb/tmr_irq_csr_tb.sv
module tmr_irq_csr_tb;
    localparam int NCH = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  expire = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [4:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    logic [4:0] m_en = '0;
    logic [4:0] m_pend = '0;

    always #4 clk = ~clk;

    tmr_irq_csr u_dut (
        .clk(clk), .rst_n(rst_n), .expire(expire), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // Reference register word built from the model state.
    function automatic logic [31:0] exp_word(input logic [4:0] e, input logic [4:0] p);
        return {22'd0, p, e};
    endfunction

    // Reference pending update: a set wins over a clear.
    function automatic logic [4:0] next_pend(input logic [4:0] p, input logic [4:0] x,
                                             input logic w, input logic [31:0] d);
        return x | (p & ~(w ? d[9:5] : 5'd0));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus, then compare both outputs on the falling edge.
    task automatic step(input logic [4:0] x, input logic w, input logic [31:0] d, input string req);
        expire = x; wr_en = w; wr_data = d;
        @(posedge clk);
        m_pend = next_pend(m_pend, x, w, d);
        if (w) m_en = d[4:0];
        @(negedge clk);
        expire = '0; wr_en = 1'b0; wr_data = '0;
        check({req, " word"}, rd_data, exp_word(m_en, m_pend));
        check({req, " irq"}, {27'd0, irq}, {27'd0, m_en & m_pend});
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 reset word", rd_data, 32'd0);
        check("R1 reset irq", {27'd0, irq}, 32'd0);
        rst_n = 1'b1;

        // R3: an expiry on a disabled channel still latches, with no irq.
        step(5'b00100, 1'b0, 32'd0, "R3 disabled latch");
        // R2: enable only channel 2; the zero pending field keeps the event (R4), irq rises (R5).
        step(5'b00000, 1'b1, 32'h0000_0004, "R2 R4 R5 enable keeps event");
        // R5: the level holds with no activity.
        step(5'b00000, 1'b0, 32'd0, "R5 R8 level held");
        // More events, then acknowledge only channel 2 (bit 7).
        step(5'b10011, 1'b0, 32'd0, "R3 multi set");
        step(5'b00000, 1'b1, 32'h0000_0084, "R4 ack single");
        // R6: expiry and clear of channel 0 on the same edge.
        step(5'b00001, 1'b1, 32'h0000_0020, "R6 set wins");
        // R7: writing all ones leaves the upper bits at zero and clears every pending bit.
        step(5'b00000, 1'b1, 32'hFFFF_FFFF, "R7 upper ignored");
        // R4: clear a bit that is already clear.
        step(5'b00000, 1'b1, 32'h0000_03E0, "R4 clear idle");

        // Random cycles: sparse and dense expiry pulses, random writes.
        for (int i = 0; i < 400; i++) begin
            logic [4:0]  x;
            logic        w;
            logic [31:0] d;
            x = (i < 200) ? (5'($urandom) & 5'($urandom)) : 5'($urandom);
            w = ($urandom % 3) == 0;
            d = $urandom;
            step(x, w, d, "R2 R3 R4 R5 R6 R7 R8 random");
        end

        // R1: reset in the middle of a run clears everything.
        step(5'b11111, 1'b1, 32'h0000_001F, "R3 refill");
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid reset word", rd_data, 32'd0);
        check("R1 mid reset irq", {27'd0, irq}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule